// File: doc/BRIEF.md
# Arbitrary Waveform Sequence Engine

This block steps through a small table of playback segments and produces one waveform-memory sample address per clock. Each segment holds a base address, a length in samples, a repeat count and the sample position at which a marker fires. The engine walks the segments in index order, from entry 0 up to a programmable last index. It repeats each segment as its count asks and emits `smp_valid` with every address it issues.

Playback is armed by software. It then begins on a rising edge of the trigger input, or at once when immediate triggering is selected. Four play modes decide what happens at segment and sequence boundaries: run the list once, loop the list forever, move one segment ahead per trigger, or play one segment per trigger. A marker pulse is stretched to a fixed minimum width so that slow logic downstream can see it. Table writes that break the length or position rules are refused and raise a sticky error flag.

Top module: `awg_seq_engine`

## Requirements
- R1: A table write is stored only when the length is a multiple of 4 and at least 16, the marker position is a multiple of 4 and below the length, and the repeat count is not zero. Any other write leaves the entry as it was and sets `cfg_err`, which stays high until reset. Reset clears `cfg_err` but does not clear the table.
- R2: While reset is held low, and after it, `smp_valid`, `marker_out` and `cfg_err` are low.
- R3: While playing, the engine issues one address per clock: base+0 up to base+length-1. It plays the segment repeat-count times in a row and then moves to the next index, wrapping to 0 after `seq_last`.
- R4: `arm` in the idle state prepares playback. With `trig_imm` high, the first address appears on the second clock after `arm` is sampled. Otherwise the first address appears on the clock after `trig_in` is first sampled high. A trigger that is already high when arming starts nothing.
- R5: Mode 0 (single) plays every segment from 0 to `seq_last` once and then goes idle with `smp_valid` low. Later triggers start nothing until the next `arm`.
- R6: Mode 1 (continuous) returns to segment 0 after `seq_last` without a gap and does not stop by itself.
- R7: Mode 2 (stepped) repeats the current segment whatever its repeat count. A trigger edge seen during playback moves to the next segment at the end of the current pass, wrapping after `seq_last`.
- R8: Mode 3 (burst) plays the current segment repeat-count times and then holds with `smp_valid` low. The next trigger plays the following segment, wrapping after `seq_last`.
- R9: `marker_out` rises on the clock after the address at the segment's marker position is issued. It stays high for exactly `MARK_HOLD` clocks (16 by default), counted again from each new marker.
- R10: `abort` returns the engine to idle on the next clock, with `smp_valid` and `marker_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | SEG_W | Entry to write |
| tbl_wr_start | input | ADDR_W | Base sample address |
| tbl_wr_len | input | ADDR_W | Length in samples |
| tbl_wr_loops | input | LOOP_W | Repeat count |
| tbl_wr_mark | input | ADDR_W | Marker sample position |
| seq_last | input | SEG_W | Index of the last segment in the list |
| play_mode | input | 2 | 0 single, 1 continuous, 2 stepped, 3 burst; latched by arm |
| trig_imm | input | 1 | Start without waiting for a trigger edge |
| arm | input | 1 | Prepare playback from idle |
| abort | input | 1 | Return to idle |
| trig_in | input | 1 | Start/advance trigger, rising edge |
| smp_addr | output | ADDR_W | Sample address to waveform memory |
| smp_valid | output | 1 | Address is live this clock |
| marker_out | output | 1 | Stretched marker pulse |
| cfg_err | output | 1 | Sticky rejected-write flag |

## Verification
The assertions assume the table is not rewritten while its entry is being played. They also assume the trigger input is already synchronous to the sample clock. The bench writes the whole table before it arms the engine and leaves it alone during playback. It drives every input half a cycle away from the active edge and holds the trigger high for a single clock, except in the one case that checks a trigger held high. Addresses and marker levels are predicted in the bench from the table it wrote, with a separate marker countdown model.

// File: rtl/awg_seq_pkg.sv
// Package: shared encodings for the waveform sequence engine.
// Assumes: play_mode values are fixed by the port contract (0..3).
package awg_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_CONT   = 2'd1,
        MODE_STEP   = 2'd2,
        MODE_BURST  = 2'd3
    } play_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/awg_seg_table.sv
// Segment table: stores base, length, repeat count and marker position for
// each entry, refuses writes that break the quantum/minimum rules, and keeps
// a sticky error flag. Assumes QUANT is a power of two. The storage is not
// reset; only the flag is.
module awg_seg_table #(
    parameter int SEG_W   = 2,
    parameter int ADDR_W  = 16,
    parameter int LOOP_W  = 24,
    parameter int QUANT   = 4,
    parameter int MIN_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [ADDR_W-1:0] wr_len,
    input  logic [LOOP_W-1:0] wr_loops,
    input  logic [ADDR_W-1:0] wr_mark,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_start,
    output logic [ADDR_W-1:0] rd_len,
    output logic [LOOP_W-1:0] rd_loops,
    output logic [ADDR_W-1:0] rd_mark,
    output logic              cfg_err
);
    localparam int DEPTH = 1 << SEG_W;
    localparam logic [ADDR_W-1:0] QMASK = ADDR_W'(QUANT - 1);

    logic [ADDR_W-1:0] start_mem [DEPTH];
    logic [ADDR_W-1:0] len_mem   [DEPTH];
    logic [LOOP_W-1:0] loops_mem [DEPTH];
    logic [ADDR_W-1:0] mark_mem  [DEPTH];
    logic              entry_ok;

    // Decide whether the presented entry obeys the layout rules.
    always_comb begin
        entry_ok = (wr_len >= ADDR_W'(MIN_LEN))
                && ((wr_len & QMASK) == '0)
                && ((wr_mark & QMASK) == '0)
                && (wr_mark < wr_len)
                && (wr_loops != '0);
    end

    // Store an accepted entry.
    always_ff @(posedge clk) begin
        if (wr_en && entry_ok) begin
            start_mem[wr_idx] <= wr_start;
            len_mem[wr_idx]   <= wr_len;
            loops_mem[wr_idx] <= wr_loops;
            mark_mem[wr_idx]  <= wr_mark;
        end
    end

    // Latch any refused write until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (wr_en && !entry_ok) begin
            cfg_err <= 1'b1;
        end
    end

    assign rd_start = start_mem[rd_idx];
    assign rd_len   = len_mem[rd_idx];
    assign rd_loops = loops_mem[rd_idx];
    assign rd_mark  = mark_mem[rd_idx];

    p_err_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    p_refused_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !entry_ok && rd_idx == wr_idx && $stable(rd_idx)) |=> $stable(rd_len));

endmodule

// File: rtl/awg_trig_edge.sv
// Rising-edge detector for the start trigger. Assumes trig_in is already
// synchronous to clk; one pulse per low-to-high transition.
module awg_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);
    logic trig_q;

    // Remember last sampled trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    assign trig_rise = trig_in && !trig_q;

    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);

endmodule

// File: rtl/awg_marker_stretch.sv
// Marker stretcher: a fire request loads a down-counter of HOLD clocks; the
// output is high while the counter is non-zero. A clear wins over a fire.
module awg_marker_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clear,
    output logic mark_out
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    // Load on fire, count down otherwise, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (fire)       cnt_q <= CW'(HOLD);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign mark_out = (cnt_q != '0);

    p_fire_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear) |=> mark_out);
    p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CW'(1) && !clear) |=> mark_out);
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !mark_out);

endmodule

// File: rtl/awg_seq_ctrl.sv
// Sequence controller: walks segments, positions and repeat counts, applies
// the latched play mode at pass and segment boundaries. Assumes the table
// entry under playback is not rewritten mid-pass and lengths are >= 1.
module awg_seq_ctrl
    import awg_seq_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int ADDR_W = 16,
    parameter int LOOP_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              abort,
    input  logic [1:0]        mode_in,
    input  logic [SEG_W-1:0]  seq_last,
    input  logic              trig_imm,
    input  logic              trig_rise,
    input  logic [ADDR_W-1:0] seg_start,
    input  logic [ADDR_W-1:0] seg_len,
    input  logic [LOOP_W-1:0] seg_loops,
    input  logic [ADDR_W-1:0] seg_mark,
    output logic [SEG_W-1:0]  seg_idx,
    output logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic              mark_fire
);
    seq_state_e        state_q;
    play_mode_e        mode_q;
    logic [ADDR_W-1:0] pos_q;
    logic [LOOP_W-1:0] loop_q;
    logic              pend_q;
    logic              go;
    logic              pass_end;
    logic              list_end;
    logic [SEG_W-1:0]  seg_next;

    // Boundary and start decode.
    always_comb begin
        go       = trig_imm || trig_rise;
        pass_end = (pos_q >= seg_len - ADDR_W'(1));
        list_end = (seg_idx == seq_last);
        seg_next = list_end ? '0 : seg_idx + 1'b1;
    end

    // Main playback state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_SINGLE;
            seg_idx <= '0;
            pos_q   <= '0;
            loop_q  <= LOOP_W'(1);
            pend_q  <= 1'b0;
        end else if (abort) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (arm) begin
                        state_q <= ST_ARMED;
                        mode_q  <= play_mode_e'(mode_in);
                        seg_idx <= '0;
                        pos_q   <= '0;
                        loop_q  <= LOOP_W'(1);
                        pend_q  <= 1'b0;
                    end
                end
                ST_ARMED, ST_HOLD: begin
                    if (go) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (trig_rise && mode_q == MODE_STEP) pend_q <= 1'b1;
                    if (!pass_end) begin
                        pos_q <= pos_q + 1'b1;
                    end else begin
                        pos_q <= '0;
                        if (mode_q == MODE_STEP) begin
                            if (pend_q) begin
                                pend_q  <= 1'b0;
                                seg_idx <= seg_next;
                            end
                        end else if (loop_q >= seg_loops) begin
                            loop_q  <= LOOP_W'(1);
                            seg_idx <= seg_next;
                            if (mode_q == MODE_BURST)
                                state_q <= ST_HOLD;
                            else if (mode_q == MODE_SINGLE && list_end)
                                state_q <= ST_IDLE;
                        end else begin
                            loop_q <= loop_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign valid     = (state_q == ST_RUN);
    assign addr      = seg_start + pos_q;
    assign mark_fire = valid && (pos_q == seg_mark);

    p_pos_in_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (pos_q < seg_len));
    p_pos_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !abort && !pass_end) |=> (pos_q == $past(pos_q) + 1'b1));
    p_hold_only_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (mode_q == MODE_BURST));
    p_loop_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode_q != MODE_STEP) |-> (loop_q != '0 && loop_q <= seg_loops));
    p_single_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !abort && mode_q == MODE_SINGLE && pass_end && list_end
         && loop_q >= seg_loops) |=> !valid);

endmodule

// File: rtl/awg_seq_engine.sv
// Top: arbitrary waveform sequence engine. Joins the segment table, trigger
// edge detector, sequence controller and marker stretcher. Assumes trig_in
// is synchronous to clk and the table is static during playback.
module awg_seq_engine #(
    parameter int SEG_W     = 2,
    parameter int ADDR_W    = 16,
    parameter int LOOP_W    = 24,
    parameter int QUANT     = 4,
    parameter int MIN_LEN   = 16,
    parameter int MARK_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [SEG_W-1:0]  tbl_wr_idx,
    input  logic [ADDR_W-1:0] tbl_wr_start,
    input  logic [ADDR_W-1:0] tbl_wr_len,
    input  logic [LOOP_W-1:0] tbl_wr_loops,
    input  logic [ADDR_W-1:0] tbl_wr_mark,
    input  logic [SEG_W-1:0]  seq_last,
    input  logic [1:0]        play_mode,
    input  logic              trig_imm,
    input  logic              arm,
    input  logic              abort,
    input  logic              trig_in,
    output logic [ADDR_W-1:0] smp_addr,
    output logic              smp_valid,
    output logic              marker_out,
    output logic              cfg_err
);
    logic [SEG_W-1:0]  seg_idx;
    logic [ADDR_W-1:0] seg_start;
    logic [ADDR_W-1:0] seg_len;
    logic [LOOP_W-1:0] seg_loops;
    logic [ADDR_W-1:0] seg_mark;
    logic              trig_rise;
    logic              mark_fire;

    awg_seg_table #(
        .SEG_W(SEG_W), .ADDR_W(ADDR_W), .LOOP_W(LOOP_W),
        .QUANT(QUANT), .MIN_LEN(MIN_LEN)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_start(tbl_wr_start),
        .wr_len(tbl_wr_len), .wr_loops(tbl_wr_loops), .wr_mark(tbl_wr_mark),
        .rd_idx(seg_idx), .rd_start(seg_start), .rd_len(seg_len),
        .rd_loops(seg_loops), .rd_mark(seg_mark), .cfg_err(cfg_err)
    );

    awg_trig_edge u_edge (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_rise(trig_rise)
    );

    awg_seq_ctrl #(
        .SEG_W(SEG_W), .ADDR_W(ADDR_W), .LOOP_W(LOOP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort),
        .mode_in(play_mode), .seq_last(seq_last), .trig_imm(trig_imm),
        .trig_rise(trig_rise), .seg_start(seg_start), .seg_len(seg_len),
        .seg_loops(seg_loops), .seg_mark(seg_mark), .seg_idx(seg_idx),
        .addr(smp_addr), .valid(smp_valid), .mark_fire(mark_fire)
    );

    awg_marker_stretch #(
        .HOLD(MARK_HOLD)
    ) u_mark (
        .clk(clk), .rst_n(rst_n), .fire(mark_fire), .clear(abort),
        .mark_out(marker_out)
    );

    p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!smp_valid && !marker_out));

endmodule

// File: tb/awg_seq_engine_test.sv
// Bench: plays a four-entry table through every mode and compares each
// address and marker level against values computed from the written table.
module awg_seq_engine_test;
    localparam int ADDR_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [1:0]  tbl_wr_idx = '0;
    logic [15:0] tbl_wr_start = '0;
    logic [15:0] tbl_wr_len = '0;
    logic [23:0] tbl_wr_loops = '0;
    logic [15:0] tbl_wr_mark = '0;
    logic [1:0]  seq_last = '0;
    logic [1:0]  play_mode = '0;
    logic        trig_imm = 1'b0;
    logic        arm = 1'b0;
    logic        abort = 1'b0;
    logic        trig_in = 1'b0;
    logic [15:0] smp_addr;
    logic        smp_valid;
    logic        marker_out;
    logic        cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    int mcnt    = 0;
    int mk_bad  = 0;
    bit trig_hold = 1'b0;
    int st [4] = '{16'h100, 16'h200, 16'h300, 16'h400};
    int ln [4] = '{16, 20, 16, 16};
    int lp [4] = '{2, 1, 3, 1};
    int mk [4] = '{8, 0, 12, 4};

    always #2 clk = ~clk;

    awg_seq_engine uut (
        .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_start(tbl_wr_start), .tbl_wr_len(tbl_wr_len),
        .tbl_wr_loops(tbl_wr_loops), .tbl_wr_mark(tbl_wr_mark),
        .seq_last(seq_last), .play_mode(play_mode), .trig_imm(trig_imm),
        .arm(arm), .abort(abort), .trig_in(trig_in), .smp_addr(smp_addr),
        .smp_valid(smp_valid), .marker_out(marker_out), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One negedge sample; checks marker against the countdown model (R9).
    task automatic obs(input bit fire_exp, output logic v, output logic [15:0] a);
        @(negedge clk);
        v = smp_valid;
        a = smp_addr;
        if (marker_out !== (mcnt != 0)) mk_bad++;
        if (fire_exp) mcnt = 16;
        else if (mcnt > 0) mcnt--;
        if (!trig_hold) trig_in = 1'b0;
    endtask

    task automatic run_range(input int s, input int from, input int to, input string req);
        int bad = 0;
        logic v;
        logic [15:0] a;
        for (int i = from; i < to; i++) begin
            obs(i == mk[s], v, a);
            if (!v || a !== 16'(st[s] + i)) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic run_pass(input int s, input string req);
        run_range(s, 0, ln[s], req);
    endtask

    task automatic idle_obs(input int n, input string req);
        int bad = 0;
        logic v;
        logic [15:0] a;
        for (int i = 0; i < n; i++) begin
            obs(1'b0, v, a);
            if (v) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic wr(input int idx, input int s, input int l, input int lps, input int m);
        tbl_wr_idx = 2'(idx); tbl_wr_start = 16'(s); tbl_wr_len = 16'(l);
        tbl_wr_loops = 24'(lps); tbl_wr_mark = 16'(m); tbl_wr_en = 1'b1;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mcnt = 0;
    endtask

    task automatic launch(input int mode, input int last, input bit imm);
        logic v;
        logic [15:0] a;
        play_mode = 2'(mode); seq_last = 2'(last); trig_imm = imm; arm = 1'b1;
        obs(1'b0, v, a);
        arm = 1'b0;
        chk("R4 armed not playing", int'(v), 0);
        if (!imm) trig_in = 1'b1;
    endtask

    task automatic abort_check(input string req);
        logic v;
        logic [15:0] a;
        abort = 1'b1;
        mcnt = 0;
        obs(1'b0, v, a);
        abort = 1'b0;
        chk(req, {30'd0, v, marker_out}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic v;
        logic [15:0] a;
        // R2: state under reset
        repeat (3) @(negedge clk);
        chk("R2 valid in reset", int'(smp_valid), 0);
        chk("R2 marker in reset", int'(marker_out), 0);
        chk("R2 err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 valid after reset", int'(smp_valid), 0);

        // R1: good entries accepted
        for (int i = 0; i < 4; i++) wr(i, st[i], ln[i], lp[i], mk[i]);
        chk("R1 good writes no err", int'(cfg_err), 0);

        // R1: each refused variant to entry 3, flag cleared by reset in between
        for (int k = 0; k < 5; k++) begin
            do_reset();
            chk("R1 err clear after reset", int'(cfg_err), 0);
            case (k)
                0: wr(3, 16'h7000, 18, 1, 0);
                1: wr(3, 16'h7000, 12, 1, 0);
                2: wr(3, 16'h7000, 16, 1, 6);
                3: wr(3, 16'h7000, 16, 0, 0);
                default: wr(3, 16'h7000, 16, 1, 16);
            endcase
            chk("R1 refused write sets err", int'(cfg_err), 1);
            @(negedge clk);
            chk("R1 err sticky", int'(cfg_err), 1);
        end
        do_reset();

        // R5/R3: single mode over all four entries (entry 3 proves refusals kept it)
        launch(0, 3, 1'b0);
        run_pass(0, "R3 seg0 pass1");
        run_pass(0, "R3 seg0 pass2");
        run_pass(1, "R3 seg1");
        for (int p = 0; p < 3; p++) run_pass(2, "R3 seg2 repeats");
        run_pass(3, "R1 entry3 unchanged");
        idle_obs(4, "R5 single stops");
        trig_in = 1'b1;
        idle_obs(4, "R5 trigger without arm ignored");
        chk("R9 marker model", mk_bad, 0);

        // R4: trigger already high at arm does not start
        trig_hold = 1'b1;
        trig_in = 1'b1;
        play_mode = 2'd0; seq_last = 2'd0; trig_imm = 1'b0; arm = 1'b1;
        obs(1'b0, v, a);
        arm = 1'b0;
        idle_obs(4, "R4 held trigger no start");
        trig_hold = 1'b0;
        trig_in = 1'b0;
        obs(1'b0, v, a);
        chk("R4 still idle", int'(v), 0);
        trig_in = 1'b1;
        run_pass(0, "R4 edge starts");
        run_pass(0, "R4 edge starts pass2");
        idle_obs(2, "R5 single last=0 stops");

        // R6/R4 immediate: continuous mode
        launch(1, 1, 1'b1);
        for (int r = 0; r < 2; r++) begin
            run_pass(0, "R6 cont seg0");
            run_pass(0, "R6 cont seg0 again");
            run_pass(1, "R6 cont seg1 then wrap");
        end
        run_range(0, 0, 10, "R6 cont third round");
        chk("R9 marker model cont", mk_bad, 0);
        chk("R9 marker high before abort", int'(marker_out), 1);
        abort_check("R10 abort mid pass");
        trig_imm = 1'b0;
        idle_obs(3, "R10 stays idle");

        // R7: stepped mode
        launch(2, 1, 1'b0);
        for (int p = 0; p < 3; p++) run_pass(0, "R7 step repeats seg0");
        run_range(0, 0, 5, "R7 step before trig");
        trig_in = 1'b1;
        run_range(0, 5, 16, "R7 step finishes pass");
        run_pass(1, "R7 step advanced");
        run_pass(1, "R7 step seg1 repeats");
        run_range(1, 0, 3, "R7 step seg1 head");
        trig_in = 1'b1;
        run_range(1, 3, 20, "R7 step seg1 tail");
        run_pass(0, "R7 step wraps");
        abort_check("R10 abort stepped");

        // R8: burst mode
        launch(3, 2, 1'b0);
        run_pass(0, "R8 burst seg0 p1");
        run_pass(0, "R8 burst seg0 p2");
        idle_obs(3, "R8 burst waits");
        trig_in = 1'b1;
        run_pass(1, "R8 burst seg1");
        idle_obs(3, "R8 burst waits 2");
        trig_in = 1'b1;
        for (int p = 0; p < 3; p++) run_pass(2, "R8 burst seg2");
        idle_obs(3, "R8 burst waits 3");
        trig_in = 1'b1;
        run_pass(0, "R8 burst wraps p1");
        run_pass(0, "R8 burst wraps p2");
        idle_obs(20, "R8 burst waits 4");
        chk("R9 marker model final", mk_bad, 0);
        chk("R1 no stray err", int'(cfg_err), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule